// File: doc/BRIEF.md
# Masked Address Breakpoint Unit

This block watches the memory accesses of a processor and raises a breakpoint request when an access hits a programmed address window. Every access presented on the access port is captured in an input register together with its kind (data read, data write or instruction fetch). It is then compared against each channel's base address under that channel's mask. A mask bit of one removes that address bit from the comparison, so a channel can cover a single word, an aligned block or a scattered set of addresses.

A match counts only when the access kind passes the channel's qualifier. It must also be armed. A per-channel countdown can hold back the request until every Nth qualified match. A sticky status flag records that at least one qualified match has happened since the channel's control word was last written. The channels are identical and fully independent. They are programmed through a plain write-enable register bus that selects a channel and one of three registers.

Top module: `addr_bkpt_unit`

## Requirements
- R1: After reset every channel is disarmed, `bkpt_req` and `match_seen` are all zero, and an access to any address raises no request.
- R2: An access with `acc_valid` high is captured at a rising clock edge. A resulting request is a one-cycle high pulse on `bkpt_req` that appears after the next rising edge, two edges after the access was presented.
- R3: An access hits a channel when every address bit whose mask bit is 0 equals the same bit of the base address. Mask bits set to 1 are ignored.
- R4: Control word bits [7:6] select the qualifier. 0 accepts any access. 1 accepts data reads only (`acc_write`=0, `acc_fetch`=0). 2 accepts data writes only (`acc_write`=1, `acc_fetch`=0). 3 accepts instruction fetches only (`acc_fetch`=1).
- R5: With control bit 8 (arm) at 0 a channel raises no request and does not set `match_seen`.
- R6: With control bit 5 (count enable) at 0, every qualified match raises a request, including matches on back-to-back cycles.
- R7: With count enable at 1 and N = control bits [4:0], a request is raised on every Nth qualified match, and N of 0 or 1 fires on every match. After firing the countdown reloads to N. A control write also reloads it to N.
- R8: `match_seen` of a channel is set by any qualified match, whether or not a request fires. It stays set until a control word write to that channel clears it.
- R9: Channels are independent. A write selects one channel with `cfg_ch` and leaves the others unchanged, and an access hitting several channels raises the request of each.
- R10: `cfg_sel` 0 writes the base, 1 writes the mask and 2 writes the control word. A write applies to an access presented in the same cycle or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 for a write access |
| acc_fetch | input | 1 | 1 for an instruction fetch |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 1 | Channel selected by the write |
| cfg_sel | input | 2 | Register selected: 0 base, 1 mask, 2 control |
| cfg_wdata | input | 32 | Register write data |
| bkpt_req | output | NUM_CH | Per-channel breakpoint request pulse |
| match_seen | output | NUM_CH | Per-channel sticky qualified-match flag |

## Verification
The hardest situation to reach is the interplay of the countdown with reloads. The bench has to see the Nth match fire, the counter reload, and the next N-1 matches stay silent. It also has to see that the sticky flag still sets on those silent matches. The stimulus programs a count of three and drives seven qualified accesses back to back, so requests are expected on the third and sixth. It then rewrites the count to 0 and to 1 to confirm that every match fires. A separate step presents a base write and a matching access in the same cycle, which proves that the write is ordered ahead of the compare.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int AW = 32;

  typedef enum logic [1:0] {
    QUAL_ANY   = 2'd0,
    QUAL_READ  = 2'd1,
    QUAL_WRITE = 2'd2,
    QUAL_FETCH = 2'd3
  } acc_qual_e;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTL  = 2'd2
  } cfg_sel_e;

  // address bits under a 0 mask bit must agree with the base
  function automatic logic addr_hit(input logic [AW-1:0] addr,
                                    input logic [AW-1:0] base,
                                    input logic [AW-1:0] mask);
    return ((addr ^ base) & ~mask) == '0;
  endfunction

  function automatic logic attr_pass(input acc_qual_e q,
                                     input logic is_wr,
                                     input logic is_fetch);
    case (q)
      QUAL_READ:  return !is_wr && !is_fetch;
      QUAL_WRITE: return is_wr && !is_fetch;
      QUAL_FETCH: return is_fetch;
      default:    return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/bkpt_addr_latch.sv
module bkpt_addr_latch
  import bkpt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic          in_write,
  input  logic          in_fetch,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          out_write,
  output logic          out_fetch
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_write <= 1'b0;
      out_fetch <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr  <= in_addr;
        out_write <= in_write;
        out_fetch <= in_fetch;
      end
    end
  end

  // R2
  latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && out_addr == $past(in_addr));
endmodule

// File: rtl/bkpt_channel.sv
module bkpt_channel
  import bkpt_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_valid,
  input  logic [AW-1:0] lat_addr,
  input  logic          lat_write,
  input  logic          lat_fetch,
  input  logic          wr_base,
  input  logic          wr_mask,
  input  logic          wr_ctl,
  input  logic [AW-1:0] wdata,
  output logic          bkpt_req,
  output logic          match_seen
);
  localparam int EN_BIT  = CNT_W;
  localparam int QUAL_LO = CNT_W + 1;
  localparam int ARM_BIT = CNT_W + 3;

  logic [AW-1:0]    base_q, mask_q;
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic             cnt_en_q, armed_q;
  acc_qual_e        qual_q;

  // named internal events
  logic addr_ok, kind_ok, qual_hit, fire, cnt_last;

  function automatic logic [CNT_W-1:0] count_after_hit(input logic [CNT_W-1:0] cur,
                                                       input logic [CNT_W-1:0] rel);
    return (cur <= CNT_W'(1)) ? rel : cur - CNT_W'(1);
  endfunction

  assign addr_ok  = addr_hit(lat_addr, base_q, mask_q);
  assign kind_ok  = attr_pass(qual_q, lat_write, lat_fetch);
  assign qual_hit = lat_valid && armed_q && addr_ok && kind_ok;
  assign cnt_last = cnt_q <= CNT_W'(1);
  assign fire     = qual_hit && (!cnt_en_q || cnt_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      mask_q     <= '0;
      reload_q   <= '0;
      cnt_q      <= '0;
      cnt_en_q   <= 1'b0;
      armed_q    <= 1'b0;
      qual_q     <= QUAL_ANY;
      match_seen <= 1'b0;
      bkpt_req   <= 1'b0;
    end else begin
      bkpt_req <= fire;
      if (wr_base) base_q <= wdata;
      if (wr_mask) mask_q <= wdata;
      if (wr_ctl) begin
        reload_q   <= wdata[CNT_W-1:0];
        cnt_q      <= wdata[CNT_W-1:0];
        cnt_en_q   <= wdata[EN_BIT];
        qual_q     <= acc_qual_e'(wdata[QUAL_LO+1:QUAL_LO]);
        armed_q    <= wdata[ARM_BIT];
        match_seen <= 1'b0;
      end else if (qual_hit) begin
        match_seen <= 1'b1;
        if (cnt_en_q) cnt_q <= count_after_hit(cnt_q, reload_q);
      end
    end
  end

  // R2
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_req |-> $past(qual_hit));
  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qual_hit && !wr_ctl |=> match_seen);
  // R5
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q && !wr_ctl |=> !bkpt_req && $stable(match_seen));
  // R6
  direct_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qual_hit && !cnt_en_q |=> bkpt_req);
  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= reload_q);
endmodule

// File: rtl/addr_bkpt_unit.sv
module addr_bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 5,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [AW-1:0]     acc_addr,
  input  logic              acc_write,
  input  logic              acc_fetch,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [NUM_CH-1:0] bkpt_req,
  output logic [NUM_CH-1:0] match_seen
);
  logic          lat_valid, lat_write, lat_fetch;
  logic [AW-1:0] lat_addr;

  bkpt_addr_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (acc_valid),
    .in_addr  (acc_addr),
    .in_write (acc_write),
    .in_fetch (acc_fetch),
    .out_valid(lat_valid),
    .out_addr (lat_addr),
    .out_write(lat_write),
    .out_fetch(lat_fetch)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel_me;
    assign sel_me = cfg_we && (cfg_ch == CH_W'(i));

    bkpt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .lat_valid (lat_valid),
      .lat_addr  (lat_addr),
      .lat_write (lat_write),
      .lat_fetch (lat_fetch),
      .wr_base   (sel_me && cfg_sel == SEL_BASE),
      .wr_mask   (sel_me && cfg_sel == SEL_MASK),
      .wr_ctl    (sel_me && cfg_sel == SEL_CTL),
      .wdata     (cfg_wdata),
      .bkpt_req  (bkpt_req[i]),
      .match_seen(match_seen[i])
    );
  end

  // R9
  unsel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we && !lat_valid |=> $stable(match_seen));
endmodule

// File: tb/sim_addr_bkpt_unit.sv
module sim_addr_bkpt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_fetch = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_ch = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  bkpt_req, match_seen;

  addr_bkpt_unit u0 (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;

  typedef struct {
    int       due;
    bit [1:0] req;
    bit [1:0] stk;
    bit       chk_stk;
    string    tag;
  } item_t;
  item_t q[$];

  // reference model state
  bit [31:0] m_base[2], m_mask[2];
  bit [4:0]  m_rel[2], m_cnt[2];
  bit        m_en[2], m_arm[2], m_stk[2];
  bit [1:0]  m_qual[2];

  function automatic bit [31:0] ctl(input int n, input bit en, input int qu, input bit arm);
    return {23'd0, arm, 2'(qu), en, 5'(n)};
  endfunction

  function automatic bit kind_ok(input bit [1:0] qu, input bit w, input bit f);
    if (qu == 2'd0) return 1'b1;
    if (qu == 2'd3) return f;
    if (f) return 1'b0;
    return (qu == 2'd2) ? w : !w;
  endfunction

  task automatic step(input bit v, input bit [31:0] a, input bit w, input bit f,
                      input bit we, input int ch, input int sel, input bit [31:0] d,
                      input string tag);
    item_t it;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_write = w; acc_fetch = f;
    cfg_we = we; cfg_ch = 1'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
    if (we) begin
      if (sel == 0) m_base[ch] = d;
      else if (sel == 1) m_mask[ch] = d;
      else if (sel == 2) begin
        m_rel[ch] = d[4:0]; m_cnt[ch] = d[4:0]; m_en[ch] = d[5];
        m_qual[ch] = d[7:6]; m_arm[ch] = d[8]; m_stk[ch] = 1'b0;
        if (q.size() > 0) q[$].chk_stk = 1'b0;
      end
    end
    it.req = '0;
    for (int c = 0; c < 2; c++) begin
      bit hit;
      hit = v && m_arm[c] && ((a & ~m_mask[c]) == (m_base[c] & ~m_mask[c]))
            && kind_ok(m_qual[c], w, f);
      if (hit) begin
        m_stk[c] = 1'b1;
        if (!m_en[c]) it.req[c] = 1'b1;
        else if (m_cnt[c] == 0 || m_cnt[c] == 1) begin
          it.req[c] = 1'b1; m_cnt[c] = m_rel[c];
        end else m_cnt[c] = m_cnt[c] - 1;
      end
    end
    it.stk = {m_stk[1], m_stk[0]};
    it.chk_stk = 1'b1;
    it.due = cyc + 2;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic acc(input bit [31:0] a, input bit w, input bit f, input string tag);
    step(1'b1, a, w, f, 1'b0, 0, 0, '0, tag);
  endtask
  task automatic wr(input int ch, input int sel, input bit [31:0] d, input string tag);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, ch, sel, d, tag);
  endtask
  task automatic idle(input string tag);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 0, 0, '0, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (bkpt_req !== it.req) begin
        fails++;
        $display("FAIL %s bkpt_req actual=%b expected=%b (cycle %0d)", it.tag, bkpt_req, it.req, cyc);
      end
      if (it.chk_stk) begin
        checks++;
        if (match_seen !== it.stk) begin
          fails++;
          $display("FAIL %s match_seen actual=%b expected=%b (cycle %0d)", it.tag, match_seen, it.stk, cyc);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1 reset state
    if (bkpt_req !== 2'b00 || match_seen !== 2'b00) begin
      fails++;
      $display("FAIL R1 reset actual=%b/%b expected=00/00", bkpt_req, match_seen);
    end
    acc(32'h0, 0, 0, "R1");          // disarmed after reset
    idle("R1");

    // R3 exact match on channel 0
    wr(0, 0, 32'h0000_1000, "R10");
    wr(0, 1, 32'h0, "R10");
    wr(0, 2, ctl(0, 0, 0, 1), "R10");
    acc(32'h0000_1000, 0, 0, "R3");
    acc(32'h0000_1004, 0, 0, "R3");
    idle("R2");                      // pulse lasts one cycle
    acc(32'h0000_1000, 1, 0, "R3");
    idle("R2");

    // R3 masked range on channel 1
    wr(1, 0, 32'h2000_0000, "R9");
    wr(1, 1, 32'h0000_00FF, "R9");
    wr(1, 2, ctl(0, 0, 0, 1), "R9");
    acc(32'h2000_00AB, 0, 0, "R3");
    acc(32'h2000_0100, 0, 0, "R3");
    acc(32'h2000_00FF, 0, 1, "R3");
    wr(1, 1, 32'h0001_0000, "R3");
    acc(32'h2001_0000, 0, 0, "R3");
    acc(32'h2001_0001, 0, 0, "R3");

    // R9 both channels on one access
    wr(1, 1, 32'h0000_00FF, "R9");
    wr(0, 0, 32'h2000_0010, "R9");
    acc(32'h2000_0010, 0, 0, "R9");
    idle("R9");

    // R4 qualifiers on channel 0
    wr(0, 2, ctl(0, 0, 1, 1), "R4");
    acc(32'h2000_0010, 1, 0, "R4");
    acc(32'h2000_0010, 0, 1, "R4");
    acc(32'h2000_0010, 0, 0, "R4");
    wr(0, 2, ctl(0, 0, 2, 1), "R4");
    acc(32'h2000_0010, 0, 0, "R4");
    acc(32'h2000_0010, 1, 0, "R4");
    acc(32'h2000_0010, 1, 1, "R4");
    wr(0, 2, ctl(0, 0, 3, 1), "R4");
    acc(32'h2000_0010, 1, 0, "R4");
    acc(32'h2000_0010, 1, 1, "R4");
    acc(32'h2000_0010, 0, 1, "R4");

    // R8 sticky clear on ch0 leaves ch1 set (R9)
    wr(0, 2, ctl(0, 0, 0, 1), "R8");
    idle("R8");
    wr(1, 0, 32'h5000_0000, "R9");
    idle("R9");
    acc(32'h2000_0010, 0, 0, "R8");
    idle("R8");

    // R7 count of three, back to back
    wr(0, 2, ctl(3, 1, 0, 1), "R7");
    for (int k = 0; k < 7; k++) acc(32'h2000_0010, 0, 0, "R7");
    idle("R7");
    wr(0, 2, ctl(0, 1, 0, 1), "R7");
    acc(32'h2000_0010, 0, 0, "R7");
    acc(32'h2000_0010, 0, 0, "R7");
    wr(0, 2, ctl(1, 1, 0, 1), "R7");
    acc(32'h2000_0010, 0, 0, "R7");
    acc(32'h2000_0010, 0, 0, "R7");
    wr(0, 2, ctl(2, 1, 0, 1), "R7");
    acc(32'h2000_0010, 0, 0, "R7");
    wr(0, 2, ctl(2, 1, 0, 1), "R7");  // rewrite reloads the count
    acc(32'h2000_0010, 0, 0, "R7");
    acc(32'h2000_0010, 0, 0, "R7");

    // R6 counter off: every match, back to back
    wr(0, 2, ctl(3, 0, 0, 1), "R6");
    for (int k = 0; k < 3; k++) acc(32'h2000_0010, 0, 0, "R6");
    idle("R6");

    // R5 disarmed
    wr(0, 2, ctl(0, 0, 0, 0), "R5");
    acc(32'h2000_0010, 0, 0, "R5");
    idle("R5");

    // R10 write and access in the same cycle
    wr(0, 2, ctl(0, 0, 0, 1), "R10");
    step(1'b1, 32'h0000_3000, 0, 0, 1'b1, 0, 0, 32'h0000_3000, "R10");
    idle("R10");

    repeat (4) idle("R2");
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule